// File: doc/BRIEF.md
# Path RDI Persistence Monitor

This block watches the remote defect field of the received path status byte, one sample per frame. A frame strobe marks the cycle in which the status byte on the input is valid. The block keeps a candidate value and counts how many frames in a row repeat it. A new value is taken as accepted only once it has been seen for a programmable number of frames in a row. The accepted value goes into a 3-bit register, and a one-cycle delta pulse reports that the accepted value has moved.

The mode select picks what is compared. In single-bit mode only the classic RDI bit takes part. In enhanced mode the three-bit field takes part. All three bits are stored on acceptance in either mode. A path AIS indication freezes the outcome: while it is present, no frame can be accepted and the persistence count starts again. A defect output follows the accepted RDI bit, so its detection and its clearing both obey the same persistence and the same AIS inhibit.

Bit numbering follows the line convention, where status bit 1 is the MSB. Bit 5 is therefore `g1_i[3]`, bit 6 is `g1_i[2]` and bit 7 is `g1_i[1]`. The accepted register holds bit 5 in `acc_o[2]`, bit 6 in `acc_o[1]` and bit 7 in `acc_o[0]`.

Top module: `rdi_path_mon`

## Requirements
- R1: After reset, `acc_o` is 3'b000, `rdip_o` is 0 and `delta_o` is 0.
- R2: With `single_bit_i` = 0, a field value `g1_i[3:1]` is accepted on the N-th consecutive non-AIS strobe carrying the same three bits. It becomes visible on `acc_o` in the cycle after that strobe. A strobe whose field differs restarts the count at 1.
- R3: With `single_bit_i` = 1, only `g1_i[3]` is compared. Frames that differ only in `g1_i[2:1]` continue the run.
- R4: On acceptance, `acc_o` takes all of `g1_i[3:1]` from the accepting strobe, in both modes.
- R5: `delta_o` is high for exactly the one cycle after an acceptance whose monitored bits differ from the previous `acc_o`. The monitored bits are `acc_o[2]` only in single-bit mode and all three bits in enhanced mode. Otherwise `delta_o` is 0.
- R6: N equals `consec_i` for values 1 to 15. A `consec_i` of 0 acts as 1.
- R7: `rdip_o` always equals the accepted bit 5, `acc_o[2]`.
- R8: A strobe with `aisp_i` = 1 changes no output. It also clears the run, so that N fresh non-AIS strobes are needed before the next acceptance.
- R9: Without `frame_i`, the values on `g1_i` and `aisp_i` have no effect on any output.
- R10: Once a value is accepted, further identical frames give no new delta. A value held for fewer than N strobes is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe: the status byte is valid |
| g1_i | input | 8 | Received path status byte, bit 1 of the line convention at index 7 |
| single_bit_i | input | 1 | 1: compare bit 5 only; 0: compare bits 5 to 7 |
| consec_i | input | 4 | Persistence count in frames (0 acts as 1) |
| aisp_i | input | 1 | Path AIS defect present |
| acc_o | output | 3 | Accepted bits 5, 6, 7 (bit 5 in MSB) |
| rdip_o | output | 1 | RDI-P defect |
| delta_o | output | 1 | One-cycle pulse on a change of the accepted value |

## Verification
Suppose the candidate or the run count holds a wrong value, for example through a wrong mask or a count that does not reset. Then `acc_o` and `rdip_o` move one strobe too early or too late, or they do not move at all. This shows in the cycle right after the strobe that should, or should not, have completed the run. A wrong accepted register shows on the next acceptance. There it gives a missing delta, or an extra one, on the cycle after that strobe. Runs of exact length N, N-1 and N+1 are driven in both modes, together with AIS strobes in the middle of a run. Each one must expose any slip in the count at once.

// File: rtl/rdi_mon_pkg.sv
package rdi_mon_pkg;
  localparam int FIELD_W = 3;
  typedef logic [FIELD_W-1:0] rdi_field_t;
  typedef enum logic {
    MODE_ENH    = 1'b0,
    MODE_SINGLE = 1'b1
  } rdi_mode_e;
endpackage

// File: rtl/rdi_field_sel.sv
module rdi_field_sel
  import rdi_mon_pkg::*;
#(
  parameter int G1_W      = 8,
  parameter int FIELD_LSB = 1
) (
  input  logic [G1_W-1:0] g1_i,
  input  logic            single_bit_i,
  output rdi_field_t      field_o,
  output rdi_field_t      mask_o
);
  localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  rdi_mode_e mode;
  assign mode    = rdi_mode_e'(single_bit_i);
  assign field_o = g1_i[FIELD_MSB:FIELD_LSB];

  // top field bit (bit 5) is always monitored
  for (genvar i = 0; i < FIELD_W; i++) begin : g_mask
    if (i == FIELD_W - 1) begin : g_top
      assign mask_o[i] = 1'b1;
    end else begin : g_low
      assign mask_o[i] = (mode == MODE_ENH);
    end
  end
endmodule

// File: rtl/rdi_persist_cnt.sv
module rdi_persist_cnt
  import rdi_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             ais_i,
  input  rdi_field_t       field_i,
  input  rdi_field_t       mask_i,
  input  logic [CNT_W-1:0] consec_i,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  rdi_field_t       cand_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, thr;
  logic             hit, live;

  assign live = strobe_i && !ais_i;
  assign thr  = (consec_i == '0) ? CNT_ONE : consec_i;
  assign hit  = (cnt_q != '0) && (((field_i ^ cand_q) & mask_i) == '0);

  always_comb begin
    if (!hit)                cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_d = CNT_MAX;
    else                     cnt_d = cnt_q + CNT_ONE;
  end

  // fire only on the strobe that reaches the threshold
  assign accept_o = live && (cnt_d == thr) && !(hit && (cnt_q == thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (strobe_i) begin
      if (ais_i) begin
        cnt_q <= '0;
      end else begin
        cand_q <= field_i;
        cnt_q  <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/rdi_accept_reg.sv
module rdi_accept_reg
  import rdi_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  rdi_field_t field_i,
  input  rdi_field_t mask_i,
  output rdi_field_t acc_o,
  output logic       rdip_o,
  output logic       delta_o
);
  rdi_field_t acc_q;
  logic       rdip_q, delta_q, moved;

  assign moved = ((field_i ^ acc_q) & mask_i) != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      rdip_q  <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      delta_q <= accept_i && moved;
      if (accept_i) begin
        acc_q  <= field_i;
        rdip_q <= field_i[FIELD_W-1];
      end
    end
  end

  assign acc_o   = acc_q;
  assign rdip_o  = rdip_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/rdi_path_mon.sv
module rdi_path_mon
  import rdi_mon_pkg::*;
#(
  parameter int G1_W      = 8,
  parameter int FIELD_LSB = 1,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [G1_W-1:0]  g1_i,
  input  logic             single_bit_i,
  input  logic [CNT_W-1:0] consec_i,
  input  logic             aisp_i,
  output logic [2:0]       acc_o,
  output logic             rdip_o,
  output logic             delta_o
);
  rdi_field_t field, mask, acc;
  logic       accept;

  rdi_field_sel #(.G1_W(G1_W), .FIELD_LSB(FIELD_LSB)) u_sel (
    .g1_i         (g1_i),
    .single_bit_i (single_bit_i),
    .field_o      (field),
    .mask_o       (mask)
  );

  rdi_persist_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (frame_i),
    .ais_i    (aisp_i),
    .field_i  (field),
    .mask_i   (mask),
    .consec_i (consec_i),
    .accept_o (accept)
  );

  rdi_accept_reg u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .field_i  (field),
    .mask_i   (mask),
    .acc_o    (acc),
    .rdip_o   (rdip_o),
    .delta_o  (delta_o)
  );

  assign acc_o = acc;
endmodule

// File: rtl/rdi_path_mon_chk.sv
module rdi_path_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       single_bit_i,
  input logic       aisp_i,
  input logic [2:0] acc_o,
  input logic       rdip_o,
  input logic       delta_o
);
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(acc_o) && $stable(rdip_o) && !delta_o)); // R9

  AST_AIS_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && aisp_i) |=> ($stable(acc_o) && $stable(rdip_o) && !delta_o)); // R8

  AST_RDIP_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdip_o == acc_o[2]); // R7

  AST_DELTA_MEANS_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_o |-> ((acc_o[2] != $past(acc_o[2])) ||
                 (!$past(single_bit_i) && (acc_o[1:0] != $past(acc_o[1:0]))))); // R5

  AST_MONITORED_MOVE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (acc_o[2] != $past(acc_o[2]))) |-> delta_o); // R5
endmodule

bind rdi_path_mon rdi_path_mon_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_i      (frame_i),
  .single_bit_i (single_bit_i),
  .aisp_i       (aisp_i),
  .acc_o        (acc_o),
  .rdip_o       (rdip_o),
  .delta_o      (delta_o)
);

// File: tb/tb_rdi_path_mon.sv
module tb_rdi_path_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [7:0] g1_i = '0;
  logic       single_bit_i = 1'b0;
  logic [3:0] consec_i = 4'd5;
  logic       aisp_i = 1'b0;
  logic [2:0] acc_o;
  logic       rdip_o, delta_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [2:0] m_cand = '0;
  int         m_cnt = 0;
  logic [2:0] m_acc = '0;
  logic       m_rdip = 1'b0;
  logic       m_delta = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  rdi_path_mon dut (
    .clk_i, .rst_ni, .frame_i, .g1_i, .single_bit_i,
    .consec_i, .aisp_i, .acc_o, .rdip_o, .delta_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] mask_of(input logic single);
    return single ? 3'b100 : 3'b111;
  endfunction

  function automatic void model_frame(input logic [7:0] g, input logic ais);
    logic [2:0] f, msk;
    int n, prev;
    bit hit, acc;
    m_delta = 1'b0;
    if (ais) begin
      m_cnt = 0;
      return;
    end
    f    = g[3:1];
    msk  = mask_of(single_bit_i);
    n    = (consec_i == 0) ? 1 : int'(consec_i);
    prev = m_cnt;
    hit  = (m_cnt != 0) && (((f ^ m_cand) & msk) == 3'b000);
    m_cnt  = !hit ? 1 : (m_cnt < 15 ? m_cnt + 1 : 15);
    m_cand = f;
    acc = (m_cnt == n) && !(hit && prev == n);
    if (acc) begin
      m_delta = ((f ^ m_acc) & msk) != 3'b000;
      m_acc   = f;
      m_rdip  = f[2];
    end
  endfunction

  // one strobe, then check, then idle cycles with noise on inputs
  task automatic frame(input logic [7:0] g, input logic ais, input int idle);
    string rq;
    @(negedge clk_i);
    g1_i = g; aisp_i = ais; frame_i = 1'b1;
    model_frame(g, ais);
    @(negedge clk_i);
    frame_i = 1'b0;
    rq = ais ? "R8" : (single_bit_i ? "R3" : "R2");
    chk({rq, " acc"}, acc_o, m_acc);
    chk("R7 rdip", rdip_o, m_rdip);
    chk("R5 delta", delta_o, m_delta);
    for (int i = 0; i < idle; i++) begin
      g1_i = 8'($urandom); aisp_i = 1'($urandom);
      @(negedge clk_i);
      chk("R9 idle acc", acc_o, m_acc);
      chk("R9 idle delta", delta_o, 0);
    end
    aisp_i = 1'b0;
  endtask

  function automatic logic [7:0] fld(input logic [2:0] f);
    return {4'($urandom), f, 1'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 acc", acc_o, 0);
    chk("R1 rdip", rdip_o, 0);
    chk("R1 delta", delta_o, 0);
    rst_ni = 1'b1;

    // R2/R10: enhanced, N=3, run of 2 then 3
    single_bit_i = 1'b0; consec_i = 4'd3;
    frame(fld(3'b101), 0, 1);
    frame(fld(3'b101), 0, 0);
    frame(fld(3'b011), 0, 0);
    frame(fld(3'b011), 0, 0);
    frame(fld(3'b011), 0, 2);
    frame(fld(3'b011), 0, 0); // R10 no re-pulse
    // R3/R4: single-bit mode, low bits vary, stored from accepting frame
    single_bit_i = 1'b1;
    frame({4'h0, 3'b101, 1'b0}, 0, 0);
    frame({4'h0, 3'b110, 1'b0}, 0, 0);
    frame({4'h0, 3'b111, 1'b0}, 0, 1);
    chk("R4 stored", acc_o, 3'b111);
    // R8: AIS mid-run restarts count
    frame(fld(3'b000), 0, 0);
    frame(fld(3'b000), 0, 0);
    frame(fld(3'b000), 1, 0);
    frame(fld(3'b000), 0, 0);
    frame(fld(3'b000), 0, 0);
    frame(fld(3'b000), 0, 0);
    chk("R8 after restart", rdip_o, 0);
    // R6: consec 0 acts as 1
    consec_i = 4'd0;
    frame(fld(3'b100), 0, 1);
    chk("R6 immediate", acc_o[2], 1);
    frame(fld(3'b000), 0, 0);
    // N=15 saturation
    single_bit_i = 1'b0; consec_i = 4'd15;
    for (int i = 0; i < 18; i++) frame(fld(3'b010), 0, 0);

    // random: runs with repeats, mode and N changing
    for (int r = 0; r < 300; r++) begin
      logic [2:0] f;
      int len;
      if ($urandom_range(0, 9) == 0) single_bit_i = 1'($urandom);
      if ($urandom_range(0, 7) == 0) consec_i = 4'($urandom_range(0, 6));
      f   = 3'($urandom);
      len = $urandom_range(1, 8);
      for (int k = 0; k < len; k++)
        frame(fld(f), ($urandom_range(0, 15) == 0), $urandom_range(0, 2));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule